// File: doc/BRIEF.md
# Clock Frequency Lock Monitor

This block decides on its own whether a derived clock is actually running at the frequency it is supposed to. It does not rely on a "locked" flag from the clock generator, because such a flag can claim lock while the output runs at half rate or some other harmonic.

A free-running counter advances on the monitored clock. Its value is turned into a Gray code and brought into the trusted reference domain through a two-flop synchronizer. The reference side cuts time into fixed windows of 1024 reference cycles. At the end of each window it takes the number of monitored edges seen in that window and compares it with an expected count plus or minus a tolerance.

A run of good windows raises the lock output. Downstream logic is held in reset until lock is raised. A long run of bad windows pulses a reset request back to the clock generator.

Top module: `freq_lock_mon`

## Requirements
- R1: While rst_ni is low, and directly after it rises, locked_o is 0, gen_reset_o is 0 and sys_reset_o is 1.
- R2: A window lasts exactly WIN_CYCLES (default 1024) reference cycles. The first window after reset only records a starting count and gives no verdict.
- R3: A window passes only when the monitored count in it lies in EXP_COUNT-TOL to EXP_COUNT+TOL inclusive (default 1008 to 1040). A monitored clock at half rate or stopped therefore fails every full window.
- R4: locked_o rises the cycle after the verdict of the PASS_NEED-th (default 4) consecutive passing window.
- R5: A single failing window drops locked_o on the cycle after its verdict and restarts the pass run.
- R6: The FAIL_LIMIT-th (default 8) consecutive failing window starts a gen_reset_o pulse lasting exactly PULSE_LEN (default 16) reference cycles, and the failure run restarts from zero. Sustained failure thus gives one pulse every 8 windows. gen_reset_o is never high while locked_o is high.
- R7: sys_reset_o is 1 whenever locked_o is 0 and is 0 whenever locked_o is 1.
- R8: A passing window clears the failure run, so scattered failures separated by passes never reach FAIL_LIMIT.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk_i | input | 1 | Trusted reference clock; all decisions are made in this domain |
| mon_clk_i | input | 1 | Derived clock under observation |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| locked_o | output | 1 | Monitored clock judged to be at the expected rate |
| gen_reset_o | output | 1 | Reset request pulse to the clock generator |
| sys_reset_o | output | 1 | Active-high reset for downstream logic, held until lock |

## Verification
The monitored clock is driven in three patterns: the correct rate with a phase offset to the reference, half rate, and stopped.

The correct rate shows that lock comes only after the priming window plus four good windows. Half rate shows that a harmonic which would pass a naive edge-activity check is rejected, and that reset requests repeat every eight windows. A stopped clock shows the same rejection and repetition when no edges arrive at all.

Each switch back to the correct rate falls in the middle of a window. This yields one mixed, failing window, and shows the failure run restart and lock recover after exactly four further passes. A final reset while locked checks that all outputs return to their idle values at once.

// File: rtl/flm_pkg.sv
`timescale 1ns/1ps
package flm_pkg;
  typedef struct packed {
    logic vld;
    logic pass;
  } verdict_t;
endpackage

// File: rtl/flm_mon_count.sv
`timescale 1ns/1ps
module flm_mon_count #(
  parameter int CW = 13
) (
  input  logic          mon_clk_i,
  input  logic          rst_ni,
  output logic [CW-1:0] gray_o
);
  logic [CW-1:0] bin_q;
  logic [CW-1:0] bin_nx;

  assign bin_nx = bin_q + CW'(1);

  always_ff @(posedge mon_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q  <= '0;
      gray_o <= '0;
    end else begin
      bin_q  <= bin_nx;
      gray_o <= bin_nx ^ (bin_nx >> 1);
    end
  end
endmodule

// File: rtl/flm_gray_sync.sv
`timescale 1ns/1ps
module flm_gray_sync #(
  parameter int CW     = 13,
  parameter int STAGES = 2
) (
  input  logic          ref_clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] gray_i,
  output logic [CW-1:0] bin_o
);
  logic [CW-1:0] stg_q [STAGES];

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= gray_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  // gray to binary: each bit is the xor of all gray bits at or above it
  genvar g;
  generate
    for (g = 0; g < CW; g++) begin : g_g2b
      assign bin_o[g] = ^(stg_q[STAGES-1] >> g);
    end
  endgenerate
endmodule

// File: rtl/flm_window.sv
`timescale 1ns/1ps
module flm_window
  import flm_pkg::*;
#(
  parameter int WIN_CYCLES = 1024,
  parameter int CW         = 13,
  parameter int EXP_COUNT  = 1024,
  parameter int TOL        = 16
) (
  input  logic          ref_clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] mon_bin_i,
  output logic          win_end_o,
  output verdict_t      verdict_o
);
  localparam int WW = $clog2(WIN_CYCLES);
  localparam logic [CW-1:0] LO = CW'(EXP_COUNT - TOL);
  localparam logic [CW-1:0] HI = CW'(EXP_COUNT + TOL);

  logic [WW-1:0] win_q;
  logic [CW-1:0] prev_q;
  logic [CW-1:0] delta;
  logic          primed_q;

  assign win_end_o = (win_q == WW'(WIN_CYCLES - 1));
  assign delta     = mon_bin_i - prev_q;

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q     <= '0;
      prev_q    <= '0;
      primed_q  <= 1'b0;
      verdict_o <= '0;
    end else begin
      verdict_o.vld <= 1'b0;
      if (win_end_o) begin
        win_q          <= '0;
        prev_q         <= mon_bin_i;
        primed_q       <= 1'b1;
        verdict_o.vld  <= primed_q;
        verdict_o.pass <= (delta >= LO) && (delta <= HI);
      end else begin
        win_q <= win_q + WW'(1);
      end
    end
  end
endmodule

// File: rtl/flm_lock_ctrl.sv
`timescale 1ns/1ps
module flm_lock_ctrl
  import flm_pkg::*;
#(
  parameter int PASS_NEED  = 4,
  parameter int FAIL_LIMIT = 8,
  parameter int PULSE_LEN  = 16
) (
  input  logic     ref_clk_i,
  input  logic     rst_ni,
  input  verdict_t verdict_i,
  output logic     locked_o,
  output logic     gen_reset_o
);
  localparam int PW = $clog2(PASS_NEED + 1);
  localparam int FW = $clog2(FAIL_LIMIT + 1);
  localparam int LW = $clog2(PULSE_LEN + 1);

  logic [PW-1:0] pass_q;
  logic [FW-1:0] fail_q;
  logic [LW-1:0] pulse_q;

  assign gen_reset_o = (pulse_q != '0);

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pass_q   <= '0;
      fail_q   <= '0;
      pulse_q  <= '0;
      locked_o <= 1'b0;
    end else begin
      if (pulse_q != '0) pulse_q <= pulse_q - LW'(1);
      if (verdict_i.vld) begin
        if (verdict_i.pass) begin
          fail_q <= '0;
          if (pass_q != PW'(PASS_NEED)) pass_q <= pass_q + PW'(1);
          if (pass_q == PW'(PASS_NEED - 1)) locked_o <= 1'b1;
        end else begin
          pass_q   <= '0;
          locked_o <= 1'b0;
          if (fail_q == FW'(FAIL_LIMIT - 1)) begin
            fail_q  <= '0;
            pulse_q <= LW'(PULSE_LEN);
          end else begin
            fail_q <= fail_q + FW'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/freq_lock_mon.sv
`timescale 1ns/1ps
module freq_lock_mon
  import flm_pkg::*;
#(
  parameter int WIN_CYCLES = 1024,
  parameter int EXP_COUNT  = 1024,
  parameter int TOL        = 16,
  parameter int PASS_NEED  = 4,
  parameter int FAIL_LIMIT = 8,
  parameter int PULSE_LEN  = 16,
  parameter int SYNC_STG   = 2
) (
  input  logic ref_clk_i,
  input  logic mon_clk_i,
  input  logic rst_ni,
  output logic locked_o,
  output logic gen_reset_o,
  output logic sys_reset_o
);
  // two spare bits keep a count far above EXP_COUNT from aliasing into range
  localparam int CW = $clog2(EXP_COUNT + TOL + 1) + 2;

  logic [CW-1:0] mon_gray;
  logic [CW-1:0] mon_bin;
  logic          win_end;
  verdict_t      verdict;

  flm_mon_count #(.CW(CW)) u_cnt (
    .mon_clk_i (mon_clk_i),
    .rst_ni    (rst_ni),
    .gray_o    (mon_gray)
  );

  flm_gray_sync #(.CW(CW), .STAGES(SYNC_STG)) u_sync (
    .ref_clk_i (ref_clk_i),
    .rst_ni    (rst_ni),
    .gray_i    (mon_gray),
    .bin_o     (mon_bin)
  );

  flm_window #(
    .WIN_CYCLES (WIN_CYCLES),
    .CW         (CW),
    .EXP_COUNT  (EXP_COUNT),
    .TOL        (TOL)
  ) u_win (
    .ref_clk_i (ref_clk_i),
    .rst_ni    (rst_ni),
    .mon_bin_i (mon_bin),
    .win_end_o (win_end),
    .verdict_o (verdict)
  );

  flm_lock_ctrl #(
    .PASS_NEED  (PASS_NEED),
    .FAIL_LIMIT (FAIL_LIMIT),
    .PULSE_LEN  (PULSE_LEN)
  ) u_ctrl (
    .ref_clk_i   (ref_clk_i),
    .rst_ni      (rst_ni),
    .verdict_i   (verdict),
    .locked_o    (locked_o),
    .gen_reset_o (gen_reset_o)
  );

  assign sys_reset_o = ~locked_o;
endmodule

// File: rtl/flm_checker.sv
`timescale 1ns/1ps
module flm_checker
  import flm_pkg::*;
#(
  parameter int WIN_CYCLES = 1024,
  parameter int PULSE_LEN  = 16
) (
  input logic     ref_clk_i,
  input logic     rst_ni,
  input logic     locked_o,
  input logic     gen_reset_o,
  input logic     sys_reset_o,
  input logic     win_end,
  input verdict_t verdict
);
  int gap_q;
  int run_q;

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q <= 0;
      run_q <= 0;
    end else begin
      gap_q <= win_end ? 0 : gap_q + 1;
      run_q <= gen_reset_o ? run_q + 1 : 0;
    end
  end

  a_r2_window_len: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    win_end |-> gap_q == WIN_CYCLES - 1);

  a_r4_lock_on_pass: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(verdict.vld && verdict.pass));

  a_r5_fail_unlocks: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (verdict.vld && !verdict.pass) |=> !locked_o);

  a_r6_pulse_start: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    $rose(gen_reset_o) |-> $past(verdict.vld && !verdict.pass));

  a_r6_pulse_len: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    run_q <= PULSE_LEN);

  a_r6_no_req_when_locked: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    gen_reset_o |-> !locked_o);

  a_r7_sys_held: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    !locked_o |-> sys_reset_o);
endmodule

bind freq_lock_mon flm_checker #(.WIN_CYCLES(WIN_CYCLES), .PULSE_LEN(PULSE_LEN)) u_chk (
  .ref_clk_i   (ref_clk_i),
  .rst_ni      (rst_ni),
  .locked_o    (locked_o),
  .gen_reset_o (gen_reset_o),
  .sys_reset_o (sys_reset_o),
  .win_end     (win_end),
  .verdict     (verdict)
);

// File: tb/freq_lock_mon_test.sv
`timescale 1ns/1ps
module freq_lock_mon_test;
  localparam int WIN = 1024;
  localparam int PLEN = 16;
  localparam logic [1:0] M_GOOD = 2'd0, M_HALF = 2'd1, M_STOP = 2'd2;

  typedef struct packed {
    logic [7:0] win;
    logic [1:0] next_mode;
    logic       lock;
    logic [3:0] pulses;
    logic [3:0] req;
  } vec_t;

  // checked at win*1024+512 ref cycles after reset release, then mode switches
  localparam vec_t VECS [12] = '{
    '{8'd0,  M_GOOD, 1'b0, 4'd0, 4'd1},  // R1 idle after reset
    '{8'd4,  M_GOOD, 1'b0, 4'd0, 4'd2},  // R2 priming window gives no verdict
    '{8'd5,  M_HALF, 1'b1, 4'd0, 4'd4},  // R4 lock after four passes
    '{8'd6,  M_HALF, 1'b0, 4'd0, 4'd5},  // R5 one failing window unlocks
    '{8'd12, M_HALF, 1'b0, 4'd0, 4'd6},  // R6 seven fails: no request yet
    '{8'd13, M_GOOD, 1'b0, 4'd1, 4'd6},  // R6 eighth fail: request
    '{8'd17, M_GOOD, 1'b0, 4'd1, 4'd8},  // R8 three passes after a fail
    '{8'd18, M_STOP, 1'b1, 4'd1, 4'd4},  // R4 relock
    '{8'd25, M_STOP, 1'b0, 4'd1, 4'd3},  // R3 stopped clock fails
    '{8'd26, M_STOP, 1'b0, 4'd2, 4'd6},  // R6 request on stopped clock
    '{8'd34, M_GOOD, 1'b0, 4'd3, 4'd6},  // R6 repeats every eight windows
    '{8'd39, M_GOOD, 1'b1, 4'd3, 4'd3}   // R3 correct rate relocks
  };

  logic ref_clk = 1'b0;
  logic mon_clk = 1'b0;
  logic rst_n = 1'b0;
  logic locked, gen_reset, sys_reset;
  logic [1:0] mode = M_GOOD;
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int pulses = 0;
  int run = 0;
  bit done = 1'b0;

  freq_lock_mon uut (
    .ref_clk_i   (ref_clk),
    .mon_clk_i   (mon_clk),
    .rst_ni      (rst_n),
    .locked_o    (locked),
    .gen_reset_o (gen_reset),
    .sys_reset_o (sys_reset)
  );

  always #4 ref_clk = ~ref_clk;

  initial begin
    #3;
    forever begin
      if (mode == M_STOP) #8;
      else if (mode == M_HALF) #8 mon_clk = ~mon_clk;
      else #4 mon_clk = ~mon_clk;
    end
  end

  always @(posedge ref_clk) if (rst_n) cyc <= cyc + 1;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // pulse width and no request while locked, R6
  always @(negedge ref_clk) begin
    if (rst_n && !done) begin
      if (gen_reset && locked) chk("R6 request while locked", 1, 0);
      if (gen_reset) run++;
      else if (run != 0) begin
        pulses++;
        chk("R6 pulse width", run, PLEN);
        run = 0;
      end
    end
  end

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge ref_clk);
    chk("R1 locked in reset", locked, 0);
    chk("R1 gen_reset in reset", gen_reset, 0);
    chk("R1 sys_reset in reset", sys_reset, 1);
    rst_n = 1'b1;
    foreach (VECS[i]) begin
      while (cyc < int'(VECS[i].win) * WIN + WIN / 2) @(negedge ref_clk);
      chk($sformatf("R%0d locked at window %0d", VECS[i].req, VECS[i].win),
          locked, VECS[i].lock);
      chk($sformatf("R7 sys_reset at window %0d", VECS[i].win), sys_reset, !VECS[i].lock);
      chk($sformatf("R%0d pulses at window %0d", VECS[i].req, VECS[i].win),
          pulses, VECS[i].pulses);
      mode = VECS[i].next_mode;
    end
    // directed: asynchronous reset while locked, R1
    @(negedge ref_clk);
    rst_n = 1'b0;
    #1;
    chk("R1 locked after reset", locked, 0);
    chk("R1 sys_reset after reset", sys_reset, 1);
    chk("R1 gen_reset after reset", gen_reset, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule